// File: doc/BRIEF.md
# Serial Control and Status Slave

This block is the serial front end of a switch driver. An external controller frames each transfer with an active-low chip select and a serial clock. During one frame the block receives a control word on the data input and, in the same clocks, returns a status word on the data output. Both words are sent least-significant bit first. When the frame closes with exactly the full word length of clocks, the received word is handed to the switch controller as `ctrl_word`. A `ctrl_valid` pulse marks the handover.

All three serial lines are sampled by a faster system clock through a synchronizer, and edges are found on the synchronized copies. On chip-select fall the block takes a snapshot of `status_in` into its transmit register. It then enables the output driver so that status bit 0 can be read without any clock. A controller may read only that bit and raise chip select again. Such a short frame, like any frame of the wrong length, commits nothing.

The frame controller is a four-state machine:
- `ST_IDLE` waits for chip-select fall. On that fall (IDLE→SHIFT) it loads the status snapshot.
- `ST_SHIFT` counts serial-clock falling edges.
- On chip-select rise, SHIFT→COMMIT is taken when the count equals the word length. Any other count takes SHIFT→DROP.
- `ST_COMMIT` copies the received word out. `ST_DROP` discards it.
- Both COMMIT and DROP return to IDLE unconditionally.

Top module: `ser_ctl_slave`

## Requirements
- R1: After reset, `ctrl_word` equals RESET_CTRL (default 16'h2000, i.e. only bit 13 set), `ctrl_valid` is 0 and `sdo_oe` is 0.
- R2: `sdo_oe` goes to 1 within three system clocks after `cs_n` falls, and returns to 0 within three system clocks after `cs_n` rises. It stays 0 while `cs_n` is high.
- R3: Once `sdo_oe` is 1 and before any serial-clock edge, `sdo` carries bit 0 of the `status_in` value taken at chip-select fall.
- R4: Status bits leave least-significant first and change on serial-clock rising edges. The first rising edge of a frame keeps bit 0. After k falling edges, the next rising edge presents bit k. Positions at or beyond the word length read 0.
- R5: `sdi` is sampled on serial-clock falling edges, and the first sampled bit becomes bit 0 of the control word.
- R6: A frame that closes after exactly W (16) serial-clock falling edges updates `ctrl_word` with the received word. It raises `ctrl_valid` for exactly one system clock, while `sdo_oe` is 0.
- R7: A frame closing after any other number of falling edges (0, fewer than W, or more than W) leaves `ctrl_word` unchanged and gives no `ctrl_valid` pulse.
- R8: Changes of `status_in` after `sdo_oe` has risen do not alter the bits shifted out in that frame.
- R9: Serial-clock and data activity while `cs_n` is high has no effect: no commit, no output enable, and the bit count of the next frame starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial control data in, LSB first |
| status_in | input | W | Live status word, captured at frame start |
| sdo | output | 1 | Serial status data out, LSB first |
| sdo_oe | output | 1 | Output enable for the tri-state pad driving `sdo` |
| ctrl_word | output | W | Last committed control word |
| ctrl_valid | output | 1 | One-clock pulse when `ctrl_word` is updated |

## Verification
The bench builds the block with its defaults: W=16, two synchronizer stages, and a reset word with only bit 13 set. It runs the serial clock with a half period of eight system clocks, which is twice the minimum sampling ratio. With that timing, every edge is seen in a known cycle and the sampled `sdo` can be compared bit by bit. The 16-bit word makes the counter's saturation value of 17 reachable with a 17-clock frame. Short reads, zero-clock frames and 8-clock frames are also exercised, so every branch out of `ST_SHIFT` is taken.

// File: rtl/scs_pkg.sv
package scs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DROP   = 2'd3
    } frame_state_t;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/scs_edge.sv
module scs_edge #(
    parameter int N = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_det
            assign rise[g] = ~prev_q[g] &  level[g];
            assign fall[g] =  prev_q[g] & ~level[g];
        end
    endgenerate
endmodule

// File: rtl/scs_frame_fsm.sv
module scs_frame_fsm
    import scs_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sclk_fall,
    output logic          load,
    output logic          in_frame,
    output logic          drive,
    output logic          commit,
    output logic [CW-1:0] bit_cnt
);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(W + 1);

    frame_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = (bit_cnt == CNT_FULL) ? ST_COMMIT : ST_DROP;
            ST_COMMIT: state_d = ST_IDLE;
            ST_DROP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load     = (state_q == ST_IDLE) && cs_fall;
        in_frame = (state_q == ST_SHIFT);
        drive    = (state_d == ST_SHIFT);
        commit   = (state_q == ST_COMMIT);
    end

    // falling-edge counter, saturating one past the full word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (load) begin
            bit_cnt <= '0;
        end else if (in_frame && sclk_fall && (bit_cnt != CNT_SAT)) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scs_datapath.sv
module scs_datapath #(
    parameter int W = 16,
    parameter logic [W-1:0] RESET_CTRL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         in_frame,
    input  logic         drive,
    input  logic         commit,
    input  logic         cnt_nonzero,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         sdi_s,
    input  logic [W-1:0] status_in,
    output logic         sdo,
    output logic         sdo_oe,
    output logic [W-1:0] ctrl_word,
    output logic         ctrl_valid
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    // transmit: snapshot at frame start, shift on rising edges after the first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= status_in;
        end else if (in_frame && sclk_rise && cnt_nonzero) begin
            tx_q <= {1'b0, tx_q[W-1:1]};
        end
    end

    // receive: LSB arrives first and walks down to bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (in_frame && sclk_fall) begin
            rx_q <= {sdi_s, rx_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdo_oe <= 1'b0;
        else        sdo_oe <= drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word  <= RESET_CTRL;
            ctrl_valid <= 1'b0;
        end else begin
            ctrl_valid <= commit;
            if (commit) ctrl_word <= rx_q;
        end
    end

    assign sdo = tx_q[0];
endmodule

// File: rtl/ser_ctl_slave.sv
module ser_ctl_slave #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [W-1:0] RESET_CTRL = 16'h2000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         sdi,
    input  logic [W-1:0] status_in,
    output logic         sdo,
    output logic         sdo_oe,
    output logic [W-1:0] ctrl_word,
    output logic         ctrl_valid
);
    localparam int CW = $clog2(W + 2);

    logic [2:0]    lines_s;
    logic [1:0]    rise, fall;
    logic          load, in_frame, drive, commit;
    logic [CW-1:0] bit_cnt;

    // bit 0: chip select (idles high), bit 1: serial clock, bit 2: data in
    scs_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdi, sclk, cs_n}),
        .sync_out (lines_s)
    );

    scs_edge #(.N(2), .RST_VAL(2'b01)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lines_s[1:0]),
        .rise  (rise),
        .fall  (fall)
    );

    scs_frame_fsm #(.W(W), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (fall[0]),
        .cs_rise   (rise[0]),
        .sclk_fall (fall[1]),
        .load      (load),
        .in_frame  (in_frame),
        .drive     (drive),
        .commit    (commit),
        .bit_cnt   (bit_cnt)
    );

    scs_datapath #(.W(W), .RESET_CTRL(RESET_CTRL)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .in_frame    (in_frame),
        .drive       (drive),
        .commit      (commit),
        .cnt_nonzero (bit_cnt != '0),
        .sclk_rise   (rise[1]),
        .sclk_fall   (fall[1]),
        .sdi_s       (lines_s[2]),
        .status_in   (status_in),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .ctrl_word   (ctrl_word),
        .ctrl_valid  (ctrl_valid)
    );
endmodule

module scs_checker #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sdo_oe,
    input logic          ctrl_valid,
    input logic [W-1:0]  ctrl_word,
    input logic [CW-1:0] bit_cnt
);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |=> !ctrl_valid);

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_valid |-> $stable(ctrl_word));

    // R6
    valid_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |-> !sdo_oe);

    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 3) && $past(cs_n, 2) && $past(cs_n, 1) && cs_n) |-> !sdo_oe);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) <= W + 1);
endmodule

bind ser_ctl_slave scs_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdo_oe     (sdo_oe),
    .ctrl_valid (ctrl_valid),
    .ctrl_word  (ctrl_word),
    .bit_cnt    (bit_cnt)
);

// File: tb/ser_ctl_slave_tb.sv
module ser_ctl_slave_tb;
    localparam int W = 16;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic [W-1:0] status_in = '0;
    logic         sdo, sdo_oe, ctrl_valid;
    logic [W-1:0] ctrl_word;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q [$];
    logic [W-1:0] model_ctrl = 16'h2000;

    always #2.5 clk = ~clk;

    ser_ctl_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .status_in(status_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every commit pulse pops the oldest expected word
    always @(negedge clk) begin
        if (rst_n && ctrl_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected commit", ctrl_word, model_ctrl);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(ctrl_word == e, "R6 committed word", ctrl_word, e);
            end
        end
    end

    // driver: one frame of nclk serial clocks
    task automatic run_frame(input logic [W-1:0] cw, input int nclk,
                             input logic [W-1:0] st, input bit change_st);
        status_in = st;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b1, "R2 enable after select", sdo_oe, 1);
        chk(sdo == st[0], "R3 bit0 before clock", sdo, st[0]);
        if (change_st) status_in = ~st;
        for (int i = 0; i < nclk; i++) begin
            sclk = 1'b1;
            sdi  = (i < W) ? cw[i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (change_st)
                chk(sdo == ((i < W) ? st[i] : 1'b0), "R8 snapshot bit", sdo, (i < W) ? st[i] : 1'b0);
            else
                chk(sdo == ((i < W) ? st[i] : 1'b0), "R4 status bit", sdo, (i < W) ? st[i] : 1'b0);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        if (nclk == W) begin
            exp_q.push_back(cw);
            model_ctrl = cw;
        end
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b0, "R2 release after deselect", sdo_oe, 0);
        repeat (6) @(negedge clk);
        if (nclk == W)
            chk(ctrl_word == model_ctrl, "R6 word after frame", ctrl_word, model_ctrl);
        else
            chk(ctrl_word == model_ctrl, "R7 word kept", ctrl_word, model_ctrl);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_word == 16'h2000, "R1 reset word", ctrl_word, 16'h2000);
        chk(sdo_oe == 1'b0, "R1 reset enable", sdo_oe, 0);
        chk(ctrl_valid == 1'b0, "R1 reset valid", ctrl_valid, 0);
        repeat (4) @(negedge clk);

        // R5: bit 0 set distinguishes LSB-first reception
        run_frame(16'h0001, 16, 16'hA5C3, 1'b0);
        run_frame(16'h807E, 16, 16'h0001, 1'b0);
        // R3 short read: no clock at all
        run_frame(16'hFFFF, 0, 16'h8001, 1'b0);
        // R7 short and long frames
        run_frame(16'h1234, 8, 16'h00FF, 1'b0);
        run_frame(16'h4321, 17, 16'h8000, 1'b0);
        // R8 status changes mid-frame
        run_frame(16'h5A5A, 16, 16'h3C96, 1'b1);

        // R9 clocks while deselected
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; sdi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        chk(sdo_oe == 1'b0, "R9 no enable while deselected", sdo_oe, 0);
        chk(ctrl_word == model_ctrl, "R9 word untouched", ctrl_word, model_ctrl);
        run_frame(16'hC3A0, 16, 16'h7E01, 1'b0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all commits seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule